// File: doc/BRIEF.md
# Load-Use Interlock and Branch Flush Controller

This block holds and flushes a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It watches the instruction in decode and the instruction in execute. When the execute instruction is a load whose destination register is a source that the decode instruction uses, it freezes the program counter and the fetch/decode register for one cycle and turns the execute-bound slot into a bubble. Once the load has moved on to memory, ordinary memory-to-execute forwarding supplies the value.

Control transfers are resolved in one stage chosen at build time. That stage can be decode (with a dedicated target adder), execute, or memory. The caller feeds the block the resolving stage's transfer kind, its sequential successor address, its raw offset field and its first source operand. The block computes the target and whether the transfer is taken. It drives the next fetch address and turns every younger in-flight instruction into a NOP on the same clock edge. The later the resolving stage, the more slots are flushed: one for decode, two for execute, three for memory. A flush never reaches writeback, so no architectural state changes. A NOP here means an instruction with every register-write and memory-write enable cleared. The datapath registers that apply these strobes sit outside the block.

Top module: `hazard_ctrl`

## Requirements
- R1: With no load-use match and no taken transfer, the outputs are as follows. `pcWrEn` and `ifIdEn` are 1, all three NOP strobes and `pcSel` are 0, and `pcNext` equals `pcFetch + 4`. This also holds while reset is applied.
- R2: A load-use stall is raised when all of the following hold:
  - `exIsLoad` is 1.
  - `exRd` is nonzero.
  - `exRd` equals `idRs1` with `idUseRs1` set, or equals `idRs2` with `idUseRs2` set.

  During the stall, `pcWrEn` and `ifIdEn` are 0, `nopIdEx` is 1, `nopIfId`, `nopExMem` and `pcSel` are 0, and `pcNext` equals `pcFetch`.
- R3: No stall is raised in any of these cases: `exIsLoad` is 0, `exRd` is register 0, or the matching source has its use flag clear.
- R4: A stall lasts exactly one cycle. If the stall condition is still present in the cycle right after a stall, no stall is raised in that cycle. Reset clears this memory, so the first cycle after reset may stall.
- R5: On a taken transfer, `pcSel` is 1, `pcWrEn` and `ifIdEn` are 1, and the number of NOP strobes raised depends on `RESOLVE`:
  - memory (2): `nopIfId`, `nopIdEx` and `nopExMem`.
  - execute (1): `nopIfId` and `nopIdEx`.
  - decode (0): `nopIfId` alone.
- R6: The target depends on `resKind`:
  - conditional kinds (1 and 2): `resPc1` plus `resImm[15:0]` sign-extended, with bits 25..16 ignored.
  - direct jumps, kind 3 and kind 4 (with link): `resPc1` plus the whole 26-bit `resImm` sign-extended.
  - register jumps, kind 5 and kind 6 (with link): `resRs1Val`.
- R7: Kind 1 is taken only when `resRs1Val` is zero, and kind 2 only when it is nonzero. Kinds 3 to 6 are always taken. A conditional kind that is not taken behaves as R1 or R2.
- R8: When a taken transfer and a load-use condition occur in the same cycle, the flush wins. The outputs are exactly those of R5, with no stall.
- R9: Kinds 0 and 7 never redirect and never flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idRs1 | input | REG_W | First source register of the decode instruction |
| idRs2 | input | REG_W | Second source register of the decode instruction |
| idUseRs1 | input | 1 | Decode instruction reads its first source |
| idUseRs2 | input | 1 | Decode instruction reads its second source |
| exIsLoad | input | 1 | Execute instruction is a load |
| exRd | input | REG_W | Destination register of the execute instruction |
| resKind | input | 3 | Transfer kind in the resolving stage (0 none, 1 branch-if-zero, 2 branch-if-nonzero, 3 jump, 4 jump-and-link, 5 register jump, 6 register jump-and-link, 7 none) |
| resPc1 | input | ADDR_W | Sequential successor address of the resolving instruction |
| resImm | input | 26 | Raw offset field of the resolving instruction |
| resRs1Val | input | ADDR_W | First source operand value of the resolving instruction |
| pcFetch | input | ADDR_W | Current fetch address |
| pcWrEn | output | 1 | Program counter write enable |
| ifIdEn | output | 1 | Fetch/decode register enable |
| nopIfId | output | 1 | Load a NOP into the fetch/decode register |
| nopIdEx | output | 1 | Load a NOP into the decode/execute register |
| nopExMem | output | 1 | Load a NOP into the execute/memory register |
| pcSel | output | 1 | Next fetch address comes from the transfer target |
| pcNext | output | ADDR_W | Next fetch address |

## Verification
The bench builds three copies side by side with `RESOLVE` set to decode, execute and memory. The same stimulus drives all three, so every flush depth of R5 and the flush-over-stall priority of R8 are compared against each other in the same cycle. The default 32-bit address width puts both sign-extension boundaries in reach: bit 15 for conditional offsets and bit 25 for direct jumps. Targets that wrap past the top of the address space are checked as well. A held load-use condition exercises the one-cycle limit of R4 over three consecutive cycles.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    RES_ID  = 2'd0,
    RES_EX  = 2'd1,
    RES_MEM = 2'd2
  } resolveStage_e;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_BEQZ = 3'd1,
    BK_BNEZ = 3'd2,
    BK_J    = 3'd3,
    BK_JL   = 3'd4,
    BK_JR   = 3'd5,
    BK_JLR  = 3'd6,
    BK_RSVD = 3'd7
  } brKind_e;

  localparam int OFF_W    = 26;
  localparam int BR_OFF_W = 16;
  localparam int KIND_W   = 3;

  // strobes from the control to the address datapath
  typedef struct packed {
    logic selTarget;
    logic holdPc;
  } redirect_t;

endpackage

// File: rtl/hazard_datapath.sv
module hazard_datapath
  import hazard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [KIND_W-1:0] resKind,
  input  logic [ADDR_W-1:0] resPc1,
  input  logic [OFF_W-1:0]  resImm,
  input  logic [ADDR_W-1:0] resRs1Val,
  input  logic [ADDR_W-1:0] pcFetch,
  input  redirect_t         redir,
  output logic              taken,
  output logic [ADDR_W-1:0] pcNext
);

  localparam int BR_EXT = ADDR_W - BR_OFF_W;
  localparam int J_EXT  = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] brOff;
  logic [ADDR_W-1:0] jOff;
  logic [ADDR_W-1:0] offSel;
  logic [ADDR_W-1:0] relTarget;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] seqPc;
  logic              useLong;
  logic              useReg;
  brKind_e           kind;

  assign kind  = brKind_e'(resKind);
  assign brOff = {{BR_EXT{resImm[BR_OFF_W-1]}}, resImm[BR_OFF_W-1:0]};
  assign jOff  = {{J_EXT{resImm[OFF_W-1]}}, resImm};

  // transfer decode: taken condition and operand choice
  always_comb begin
    taken   = 1'b0;
    useLong = 1'b0;
    useReg  = 1'b0;
    case (kind)
      BK_BEQZ: taken = (resRs1Val == '0);
      BK_BNEZ: taken = (resRs1Val != '0);
      BK_J, BK_JL: begin
        taken   = 1'b1;
        useLong = 1'b1;
      end
      BK_JR, BK_JLR: begin
        taken  = 1'b1;
        useReg = 1'b1;
      end
      default: taken = 1'b0;
    endcase
  end

  // one shared target adder, offset width picked ahead of it
  assign offSel    = useLong ? jOff : brOff;
  assign relTarget = resPc1 + offSel;
  assign target    = useReg ? resRs1Val : relTarget;
  assign seqPc     = pcFetch + ADDR_W'(4);

  always_comb begin
    if (redir.selTarget)   pcNext = target;
    else if (redir.holdPc) pcNext = pcFetch;
    else                   pcNext = seqPc;
  end

endmodule

// File: rtl/hazard_control.sv
module hazard_control
  import hazard_pkg::*;
#(
  parameter int            REG_W   = 5,
  parameter resolveStage_e RESOLVE = RES_MEM
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idUseRs1,
  input  logic             idUseRs2,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exRd,
  input  logic             taken,
  output logic             pcWrEn,
  output logic             ifIdEn,
  output logic             nopIfId,
  output logic             nopIdEx,
  output logic             nopExMem,
  output redirect_t        redir
);

  // bit 0: fetch/decode, bit 1: decode/execute, bit 2: execute/memory
  logic [2:0] flushMask;

  generate
    if (RESOLVE == RES_MEM) begin : gMem
      assign flushMask = 3'b111;
    end else if (RESOLVE == RES_EX) begin : gEx
      assign flushMask = 3'b011;
    end else begin : gId
      assign flushMask = 3'b001;
    end
  endgenerate

  logic rs1Hit;
  logic rs2Hit;
  logic loadUse;
  logic stallNow;
  logic stalledLast;

  assign rs1Hit   = idUseRs1 && (idRs1 == exRd);
  assign rs2Hit   = idUseRs2 && (idRs2 == exRd);
  assign loadUse  = exIsLoad && (exRd != '0) && (rs1Hit || rs2Hit);
  // older transfer wins; never stall twice in a row
  assign stallNow = loadUse && !stalledLast && !taken;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stalledLast <= 1'b0;
    else       stalledLast <= stallNow;
  end

  assign pcWrEn          = !stallNow;
  assign ifIdEn          = !stallNow;
  assign nopIfId         = taken && flushMask[0];
  assign nopIdEx         = (taken && flushMask[1]) || stallNow;
  assign nopExMem        = taken && flushMask[2];
  assign redir.selTarget = taken;
  assign redir.holdPc    = stallNow;

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int            ADDR_W  = 32,
  parameter int            REG_W   = 5,
  parameter resolveStage_e RESOLVE = RES_MEM
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  idRs1,
  input  logic [REG_W-1:0]  idRs2,
  input  logic              idUseRs1,
  input  logic              idUseRs2,
  input  logic              exIsLoad,
  input  logic [REG_W-1:0]  exRd,
  input  logic [2:0]        resKind,
  input  logic [ADDR_W-1:0] resPc1,
  input  logic [25:0]       resImm,
  input  logic [ADDR_W-1:0] resRs1Val,
  input  logic [ADDR_W-1:0] pcFetch,
  output logic              pcWrEn,
  output logic              ifIdEn,
  output logic              nopIfId,
  output logic              nopIdEx,
  output logic              nopExMem,
  output logic              pcSel,
  output logic [ADDR_W-1:0] pcNext
);

  redirect_t redir;
  logic      taken;

  hazard_control #(
    .REG_W  (REG_W),
    .RESOLVE(RESOLVE)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .idRs1   (idRs1),
    .idRs2   (idRs2),
    .idUseRs1(idUseRs1),
    .idUseRs2(idUseRs2),
    .exIsLoad(exIsLoad),
    .exRd    (exRd),
    .taken   (taken),
    .pcWrEn  (pcWrEn),
    .ifIdEn  (ifIdEn),
    .nopIfId (nopIfId),
    .nopIdEx (nopIdEx),
    .nopExMem(nopExMem),
    .redir   (redir)
  );

  hazard_datapath #(
    .ADDR_W(ADDR_W)
  ) u_datapath (
    .resKind  (resKind),
    .resPc1   (resPc1),
    .resImm   (resImm),
    .resRs1Val(resRs1Val),
    .pcFetch  (pcFetch),
    .redir    (redir),
    .taken    (taken),
    .pcNext   (pcNext)
  );

  assign pcSel = redir.selTarget;

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk
  import hazard_pkg::*;
#(
  parameter int            ADDR_W  = 32,
  parameter int            REG_W   = 5,
  parameter resolveStage_e RESOLVE = RES_MEM
) (
  input logic              clk,
  input logic              rstN,
  input logic              exIsLoad,
  input logic [REG_W-1:0]  exRd,
  input logic [2:0]        resKind,
  input logic [ADDR_W-1:0] resRs1Val,
  input logic [ADDR_W-1:0] pcFetch,
  input logic              pcWrEn,
  input logic              ifIdEn,
  input logic              nopIfId,
  input logic              nopIdEx,
  input logic              nopExMem,
  input logic              pcSel,
  input logic [ADDR_W-1:0] pcNext
);

  localparam int FLUSH_N = (RESOLVE == RES_MEM) ? 3 : (RESOLVE == RES_EX) ? 2 : 1;

  AST_STALL_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    !pcWrEn |-> (!ifIdEn && nopIdEx && !nopIfId && !nopExMem && !pcSel && pcNext == pcFetch)); // R2

  AST_NO_STALL_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!exIsLoad || exRd == '0) |-> (pcWrEn && ifIdEn)); // R3

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !pcWrEn |=> pcWrEn); // R4

  AST_FLUSH_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    pcSel |-> ($countones({nopIfId, nopIdEx, nopExMem}) == FLUSH_N)); // R5

  AST_REG_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (resKind == 3'd5 || resKind == 3'd6) |-> (pcSel && pcNext == resRs1Val)); // R6

  AST_FLUSH_BEATS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    pcSel |-> (pcWrEn && ifIdEn)); // R8

  AST_IDLE_KINDS: assert property (@(posedge clk) disable iff (!rstN)
    (resKind == 3'd0 || resKind == 3'd7) |-> (!pcSel && !nopIfId && !nopExMem)); // R9

endmodule

bind hazard_ctrl hazard_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .REG_W  (REG_W),
  .RESOLVE(RESOLVE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .exIsLoad (exIsLoad),
  .exRd     (exRd),
  .resKind  (resKind),
  .resRs1Val(resRs1Val),
  .pcFetch  (pcFetch),
  .pcWrEn   (pcWrEn),
  .ifIdEn   (ifIdEn),
  .nopIfId  (nopIfId),
  .nopIdEx  (nopIdEx),
  .nopExMem (nopExMem),
  .pcSel    (pcSel),
  .pcNext   (pcNext)
);

// File: tb/hazard_ctrl_bench.sv
module hazard_ctrl_bench;
  import hazard_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  idRs1 = '0;
  logic [4:0]  idRs2 = '0;
  logic        idUseRs1 = 1'b0;
  logic        idUseRs2 = 1'b0;
  logic        exIsLoad = 1'b0;
  logic [4:0]  exRd = '0;
  logic [2:0]  resKind = 3'd0;
  logic [31:0] resPc1 = 32'h0000_1000;
  logic [25:0] resImm = '0;
  logic [31:0] resRs1Val = '0;
  logic [31:0] pcFetch = 32'h0000_2000;

  // per build: {pcWrEn, ifIdEn, nopIfId, nopIdEx, nopExMem, pcSel}
  logic [5:0]  flags [3];
  logic [31:0] nxts  [3];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // index 0: decode, 1: execute, 2: memory resolution
  for (genvar g = 0; g < 3; g++) begin : gMode
    hazard_ctrl #(
      .ADDR_W (32),
      .REG_W  (5),
      .RESOLVE(resolveStage_e'(g))
    ) u_hazard_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .idRs1    (idRs1),
      .idRs2    (idRs2),
      .idUseRs1 (idUseRs1),
      .idUseRs2 (idUseRs2),
      .exIsLoad (exIsLoad),
      .exRd     (exRd),
      .resKind  (resKind),
      .resPc1   (resPc1),
      .resImm   (resImm),
      .resRs1Val(resRs1Val),
      .pcFetch  (pcFetch),
      .pcWrEn   (flags[g][5]),
      .ifIdEn   (flags[g][4]),
      .nopIfId  (flags[g][3]),
      .nopIdEx  (flags[g][2]),
      .nopExMem (flags[g][1]),
      .pcSel    (flags[g][0]),
      .pcNext   (nxts[g])
    );
  end

  task automatic expectAll(string req, logic stl, logic tk, logic [31:0] nxt);
    for (int g = 0; g < 3; g++) begin
      logic [5:0] e;
      e = {!stl, !stl, tk, stl || (tk && g >= 1), tk && g == 2, tk};
      checks++;
      if (flags[g] !== e || nxts[g] !== nxt) begin
        errors++;
        $display("FAIL %s build%0d flags=%b next=%h expected flags=%b next=%h",
                 req, g, flags[g], nxts[g], e, nxt);
      end
    end
  endtask

  task automatic idleIn();
    idUseRs1 = 1'b0; idUseRs2 = 1'b0; exIsLoad = 1'b0; exRd = '0;
    idRs1 = '0; idRs2 = '0; resKind = 3'd0; resImm = '0; resRs1Val = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    idleIn();
    #1;
  endtask

  task automatic testReset();
    idleIn();
    pcFetch = 32'h0000_2000;
    @(negedge clk); #1;
    expectAll("R1 reset", 1'b0, 1'b0, 32'h0000_2004);
    @(negedge clk);
    rstN = 1'b1;
    pcFetch = 32'hFFFF_FFFC;
    #1;
    expectAll("R1 wrap", 1'b0, 1'b0, 32'h0000_0000);
  endtask

  task automatic testLoadUse();
    settle();
    pcFetch = 32'h0000_3000;
    @(negedge clk);
    exIsLoad = 1'b1; exRd = 5'd7; idRs1 = 5'd7; idUseRs1 = 1'b1; #1;
    expectAll("R2 rs1", 1'b1, 1'b0, 32'h0000_3000);
    @(negedge clk); #1;
    expectAll("R4 second", 1'b0, 1'b0, 32'h0000_3004);
    @(negedge clk); #1;
    expectAll("R4 third", 1'b1, 1'b0, 32'h0000_3000);
    settle();
    @(negedge clk);
    exIsLoad = 1'b1; exRd = 5'd19; idRs1 = 5'd3; idUseRs1 = 1'b1;
    idRs2 = 5'd19; idUseRs2 = 1'b1; #1;
    expectAll("R2 rs2", 1'b1, 1'b0, 32'h0000_3000);
  endtask

  task automatic testNoStall();
    settle();
    pcFetch = 32'h0000_4000;
    @(negedge clk);
    exIsLoad = 1'b1; exRd = 5'd0; idRs1 = 5'd0; idUseRs1 = 1'b1; #1;
    expectAll("R3 reg0", 1'b0, 1'b0, 32'h0000_4004);
    @(negedge clk);
    exRd = 5'd9; idRs1 = 5'd9; idUseRs1 = 1'b0; idRs2 = 5'd9; idUseRs2 = 1'b0; #1;
    expectAll("R3 unused", 1'b0, 1'b0, 32'h0000_4004);
    @(negedge clk);
    exIsLoad = 1'b0; idUseRs1 = 1'b1; idUseRs2 = 1'b1; #1;
    expectAll("R3 not load", 1'b0, 1'b0, 32'h0000_4004);
    @(negedge clk);
    exIsLoad = 1'b1; idRs1 = 5'd8; idRs2 = 5'd10; #1;
    expectAll("R3 mismatch", 1'b0, 1'b0, 32'h0000_4004);
  endtask

  task automatic testTransfers();
    settle();
    pcFetch = 32'h0000_5000; resPc1 = 32'h0000_1000;
    @(negedge clk);
    resKind = 3'd1; resImm = 26'h000_FFF8; resRs1Val = 32'd0; #1;
    expectAll("R6 R7 R5 beqz taken", 1'b0, 1'b1, 32'h0000_0FF8);
    @(negedge clk);
    resRs1Val = 32'd5; #1;
    expectAll("R7 beqz not taken", 1'b0, 1'b0, 32'h0000_5004);
    @(negedge clk);
    resKind = 3'd2; resImm = 26'h155_8000; #1;
    expectAll("R6 bnez taken high bits", 1'b0, 1'b1, 32'hFFFF_9000);
    @(negedge clk);
    resRs1Val = 32'd0; #1;
    expectAll("R7 bnez not taken", 1'b0, 1'b0, 32'h0000_5004);
    @(negedge clk);
    resKind = 3'd3; resImm = 26'h200_0000; #1;
    expectAll("R6 jump long neg", 1'b0, 1'b1, 32'hFE00_1000);
    @(negedge clk);
    resKind = 3'd4; resImm = 26'h000_1234; #1;
    expectAll("R6 jump link", 1'b0, 1'b1, 32'h0000_2234);
    @(negedge clk);
    resKind = 3'd5; resRs1Val = 32'h0000_2468; #1;
    expectAll("R6 reg jump", 1'b0, 1'b1, 32'h0000_2468);
    @(negedge clk);
    resKind = 3'd6; resRs1Val = 32'h8000_0010; #1;
    expectAll("R6 reg jump link", 1'b0, 1'b1, 32'h8000_0010);
    @(negedge clk);
    resKind = 3'd0; resRs1Val = 32'd0; #1;
    expectAll("R9 kind0", 1'b0, 1'b0, 32'h0000_5004);
    @(negedge clk);
    resKind = 3'd7; #1;
    expectAll("R9 kind7", 1'b0, 1'b0, 32'h0000_5004);
  endtask

  task automatic testPriority();
    settle();
    pcFetch = 32'h0000_6000;
    @(negedge clk);
    exIsLoad = 1'b1; exRd = 5'd4; idRs1 = 5'd4; idUseRs1 = 1'b1;
    resKind = 3'd5; resRs1Val = 32'h0000_7000; #1;
    expectAll("R8 flush over stall", 1'b0, 1'b1, 32'h0000_7000);
    @(negedge clk);
    resKind = 3'd0; #1;
    expectAll("R8 stall after flush", 1'b1, 1'b0, 32'h0000_6000);
  endtask

  initial begin
    testReset();
    testLoadUse();
    testNoStall();
    testTransfers();
    testPriority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule